// File: doc/BRIEF.md
# Fast page mode DRAM controller

This block sits between a synchronous request port and an asynchronous DRAM with a multiplexed address bus and an 8-bit data bus. Each accepted request carries a 19-bit word address, a write flag and write data. The controller splits the address into a row and a column. It drives the row strobe, the column strobe, the write and output enables and the 10-bit address bus so that every analog timing window is met. All windows are whole clock counts derived from nanosecond parameters.

After an access the row is left open. A later request to the same row costs only a column-strobe cycle. A request to a different row, a refresh request, or a row that has been open too long makes the controller close the row and wait out the row precharge. Refresh itself is outside the block. A request/grant pair only hands over a precharged, idle device.

Top module: `fpm_dram_ctrl`

## Requirements
- R1: The row is req_addr_i[18:9] and is on addr_o[9:0] when ras_n_o falls. The column is req_addr_i[8:0] and is on addr_o[8:0], with addr_o[9] = 0, when cas_n_o falls. Strobe cycles occur in request order.
- R2: Once ras_n_o has fallen it stays low for at least ceil(T_RAS_NS/CLK_NS) cycles, and it rises only while cas_n_o is high.
- R3: ras_n_o stays high for at least ceil(T_RP_NS/CLK_NS) cycles before it falls again.
- R4: The row address holds for at least ceil(T_RAH_NS/CLK_NS) cycles after ras_n_o falls. cas_n_o falls no earlier than ceil(T_RCD_NS/CLK_NS) cycles after ras_n_o falls, and only while ras_n_o is low. The column address holds for at least ceil(T_CAH_NS/CLK_NS) cycles after cas_n_o falls.
- R5: cas_n_o stays low for at least ceil(T_CAS_NS/CLK_NS) cycles. Between page cycles it stays high for at least ceil(T_CP_NS/CLK_NS) cycles. Successive cas_n_o falls within one row are at least ceil(T_PC_NS/CLK_NS) cycles apart.
- R6: For a write, we_n_o is low at the cycle cas_n_o falls, oe_n_o is high, dq_oe_o is high and dq_o carries the write data. we_n_o is never low while cas_n_o is high.
- R7: For a read, we_n_o is high, oe_n_o is low and dq_oe_o is low while cas_n_o is low. dq_i is sampled only after the row, column-strobe and column-address access times have all elapsed. The sampled byte is returned on rd_data_o with a one-cycle rd_valid_o pulse, in request order.
- R8: A request to the open row, while the row-open limit has not been reached, makes no ras_n_o transition.
- R9: A request to a row other than the open one closes the row, precharges, and opens the new row with a fresh ras_n_o fall.
- R10: While ref_req_i is high no request is accepted. ref_gnt_o is high only while ras_n_o and cas_n_o are high and the row precharge has elapsed. An open row is closed to grant. After the grant, the next access opens a fresh row.
- R11: ras_n_o never stays low longer than ceil(T_RASMAX_NS/CLK_NS) cycles. An idle open row is closed on its own before that limit.
- R12: In reset all strobes and enables are high, dq_oe_o and rd_valid_o are low, and req_ready_o is high once reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request accepted when high with valid |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 19 | Word address, row in upper 10 bits |
| req_wdata_i | input | 8 | Write data |
| rd_valid_o | output | 1 | One-cycle read data strobe |
| rd_data_o | output | 8 | Read data |
| ref_req_i | input | 1 | Refresh wants the device |
| ref_gnt_o | output | 1 | Device is closed and precharged for refresh |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| oe_n_o | output | 1 | Output enable, active low |
| addr_o | output | 10 | Multiplexed row/column address |
| dq_o | output | 8 | Write data to device |
| dq_oe_o | output | 1 | Drive enable for dq_o |
| dq_i | input | 8 | Read data from device |

## Verification
With the default 8 ns clock, a read to a closed row raises rd_valid_o 9 cycles after the accepting edge and a row-hit read raises it 5 cycles after. A miss from an open row adds the close wait and the precharge. The bench never assumes these latencies. A scoreboard matches strobe cycles and returned bytes in order, whenever they appear. The device model samples the pins mid-cycle and counts the cycles each pin level lasts, so every window in R2 to R5 is checked as an exact cycle count. The model also drives a garbage byte until the access times are met, which exposes any early sample.

// File: rtl/fpm_pkg.sv
package fpm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_RCD, ST_CAS, ST_CP, ST_OPEN, ST_CLOSE, ST_PRE
  } st_e;

  function automatic int ns2cyc(int ns, int clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/fpm_timer.sv
module fpm_timer #(
  parameter int W = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic [W-1:0] cnt_o,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/fpm_row_track.sv
module fpm_row_track #(
  parameter int RW      = 10,
  parameter int AGW     = 14,
  parameter int MAX_CYC = 12500,
  parameter int LIM_CYC = 12490
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           open_i,
  input  logic           close_i,
  input  logic [RW-1:0]  row_i,
  input  logic [RW-1:0]  cmp_i,
  output logic [AGW-1:0] age_o,
  output logic           expire_o,
  output logic           hit_o
);
  logic           open_q;
  logic [RW-1:0]  row_q;
  logic [AGW-1:0] age_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q <= 1'b0;
      row_q  <= '0;
      age_q  <= '0;
    end else if (open_i) begin
      open_q <= 1'b1;
      row_q  <= row_i;
      age_q  <= '0;
    end else if (close_i) begin
      open_q <= 1'b0;
      age_q  <= '0;
    end else if (open_q && age_q != AGW'(MAX_CYC)) begin
      age_q  <= age_q + 1'b1;
    end
  end

  assign age_o    = age_q;
  assign expire_o = open_q && (age_q >= AGW'(LIM_CYC));
  assign hit_o    = open_q && (row_q == cmp_i) && !expire_o;

  AST_OPEN_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    open_q |-> age_q < AGW'(MAX_CYC)); // R11
  AST_OPEN_ONCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    open_i |-> !open_q); // R9
endmodule

// File: rtl/fpm_dram_ctrl.sv
module fpm_dram_ctrl
  import fpm_pkg::*;
#(
  parameter int AW          = 19,
  parameter int RW          = 10,
  parameter int CW          = 9,
  parameter int DW          = 8,
  parameter int CLK_NS      = 8,
  parameter int T_RAS_NS    = 60,
  parameter int T_RP_NS     = 40,
  parameter int T_CAS_NS    = 10,
  parameter int T_CP_NS     = 10,
  parameter int T_RAH_NS    = 10,
  parameter int T_CAH_NS    = 10,
  parameter int T_RCD_NS    = 20,
  parameter int T_PC_NS     = 25,
  parameter int T_RSH_NS    = 15,
  parameter int T_RAC_NS    = 60,
  parameter int T_CAC_NS    = 15,
  parameter int T_AA_NS     = 30,
  parameter int T_RASMAX_NS = 100000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic          req_we_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_wdata_i,
  output logic          rd_valid_o,
  output logic [DW-1:0] rd_data_o,
  input  logic          ref_req_i,
  output logic          ref_gnt_o,
  output logic          ras_n_o,
  output logic          cas_n_o,
  output logic          we_n_o,
  output logic          oe_n_o,
  output logic [RW-1:0] addr_o,
  output logic [DW-1:0] dq_o,
  output logic          dq_oe_o,
  input  logic [DW-1:0] dq_i
);
  localparam int RAS_CYC  = ns2cyc(T_RAS_NS, CLK_NS);
  localparam int RP_CYC   = imax(ns2cyc(T_RP_NS, CLK_NS), 1);
  localparam int RAH_CYC  = imax(ns2cyc(T_RAH_NS, CLK_NS), 1);
  localparam int RCD_CYC  = imax(ns2cyc(T_RCD_NS, CLK_NS), RAH_CYC);
  localparam int RAC_CYC  = imax(ns2cyc(T_RAC_NS, CLK_NS), 1);
  localparam int CASL_CYC = imax(imax(imax(ns2cyc(T_CAS_NS, CLK_NS), ns2cyc(T_CAH_NS, CLK_NS)),
                                      imax(ns2cyc(T_CAC_NS, CLK_NS), ns2cyc(T_AA_NS, CLK_NS))),
                                 imax(ns2cyc(T_RSH_NS, CLK_NS), 1));
  localparam int CP_CYC   = imax(imax(ns2cyc(T_CP_NS, CLK_NS), ns2cyc(T_PC_NS, CLK_NS) - CASL_CYC), 1);
  localparam int MAX_CYC  = ns2cyc(T_RASMAX_NS, CLK_NS);
  localparam int LIM_CYC  = MAX_CYC - CASL_CYC - CP_CYC - 3;
  localparam int TMAX     = imax(imax(RCD_CYC, CASL_CYC), imax(CP_CYC, RP_CYC));
  localparam int TW       = $clog2(TMAX + 1);
  localparam int AGW      = $clog2(MAX_CYC + 1);

  st_e           st_q, st_d;
  logic          pend_q, cur_we_q;
  logic [RW-1:0] cur_row_q;
  logic [CW-1:0] cur_col_q;
  logic [DW-1:0] cur_wd_q;
  logic          ras_n_q, cas_n_q, we_n_q, oe_n_q, dq_oe_q, rd_v_q;
  logic [RW-1:0] addr_q;
  logic [DW-1:0] dq_q, rd_d_q;

  logic          tmr_ld, tmr_zero;
  logic [TW-1:0] tmr_val, tmr_cnt;
  logic [AGW-1:0] age;
  logic          expire, hit;
  logic          go_ras, go_cas, end_cas, go_close, col_addr, accept;

  fpm_timer #(.W(TW)) u_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(tmr_ld), .val_i(tmr_val),
    .cnt_o(tmr_cnt), .zero_o(tmr_zero)
  );

  fpm_row_track #(.RW(RW), .AGW(AGW), .MAX_CYC(MAX_CYC), .LIM_CYC(LIM_CYC)) u_trk (
    .clk_i(clk_i), .rst_ni(rst_ni), .open_i(go_ras), .close_i(go_close),
    .row_i(cur_row_q), .cmp_i(cur_row_q), .age_o(age), .expire_o(expire), .hit_o(hit)
  );

  assign req_ready_o = (st_q == ST_IDLE || (st_q == ST_OPEN && !expire)) && !pend_q && !ref_req_i;
  assign ref_gnt_o   = (st_q == ST_IDLE) && !pend_q && ref_req_i;
  assign accept      = req_valid_i && req_ready_o;

  always_comb begin
    st_d     = st_q;
    tmr_ld   = 1'b0;
    tmr_val  = '0;
    go_ras   = 1'b0;
    go_cas   = 1'b0;
    end_cas  = 1'b0;
    go_close = 1'b0;
    col_addr = 1'b0;
    unique case (st_q)
      ST_IDLE: if (pend_q) begin
        go_ras = 1'b1; tmr_ld = 1'b1; tmr_val = TW'(RCD_CYC - 1); st_d = ST_RCD;
      end
      ST_RCD: begin
        if (tmr_zero) begin
          go_cas = 1'b1; tmr_ld = 1'b1; tmr_val = TW'(CASL_CYC - 1); st_d = ST_CAS;
        end else if (tmr_cnt <= TW'(RCD_CYC - RAH_CYC)) begin
          col_addr = 1'b1;
        end
      end
      // read waits for the row access time as well
      ST_CAS: if (tmr_zero && (cur_we_q || age >= AGW'(RAC_CYC - 1))) begin
        end_cas = 1'b1; tmr_ld = 1'b1; tmr_val = TW'(CP_CYC - 1); st_d = ST_CP;
      end
      ST_CP: if (tmr_zero) st_d = ST_OPEN;
      ST_OPEN: begin
        if (pend_q) begin
          if (hit) begin
            go_cas = 1'b1; tmr_ld = 1'b1; tmr_val = TW'(CASL_CYC - 1); st_d = ST_CAS;
          end else begin
            st_d = ST_CLOSE;
          end
        end else if (ref_req_i || expire) begin
          st_d = ST_CLOSE;
        end
      end
      ST_CLOSE: if (age >= AGW'(RAS_CYC - 1)) begin
        go_close = 1'b1; tmr_ld = 1'b1; tmr_val = TW'(RP_CYC - 1); st_d = ST_PRE;
      end
      ST_PRE: if (tmr_zero) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      pend_q    <= 1'b0;
      cur_we_q  <= 1'b0;
      cur_row_q <= '0;
      cur_col_q <= '0;
      cur_wd_q  <= '0;
      ras_n_q   <= 1'b1;
      cas_n_q   <= 1'b1;
      we_n_q    <= 1'b1;
      oe_n_q    <= 1'b1;
      dq_oe_q   <= 1'b0;
      addr_q    <= '0;
      dq_q      <= '0;
      rd_v_q    <= 1'b0;
      rd_d_q    <= '0;
    end else begin
      st_q   <= st_d;
      rd_v_q <= 1'b0;
      if (accept) begin
        pend_q    <= 1'b1;
        cur_we_q  <= req_we_i;
        cur_row_q <= req_addr_i[AW-1 -: RW];
        cur_col_q <= req_addr_i[CW-1:0];
        cur_wd_q  <= req_wdata_i;
      end
      if (go_ras) begin
        ras_n_q <= 1'b0;
        addr_q  <= cur_row_q;
      end
      if (col_addr) addr_q <= RW'(cur_col_q);
      if (go_cas) begin
        cas_n_q <= 1'b0;
        addr_q  <= RW'(cur_col_q);
        we_n_q  <= !cur_we_q;
        oe_n_q  <= cur_we_q;
        dq_oe_q <= cur_we_q;
        dq_q    <= cur_wd_q;
      end
      if (end_cas) begin
        cas_n_q <= 1'b1;
        we_n_q  <= 1'b1;
        oe_n_q  <= 1'b1;
        dq_oe_q <= 1'b0;
        pend_q  <= 1'b0;
        if (!cur_we_q) begin
          rd_v_q <= 1'b1;
          rd_d_q <= dq_i;
        end
      end
      if (go_close) ras_n_q <= 1'b1;
    end
  end

  assign ras_n_o    = ras_n_q;
  assign cas_n_o    = cas_n_q;
  assign we_n_o     = we_n_q;
  assign oe_n_o     = oe_n_q;
  assign addr_o     = addr_q;
  assign dq_o       = dq_q;
  assign dq_oe_o    = dq_oe_q;
  assign rd_valid_o = rd_v_q;
  assign rd_data_o  = rd_d_q;

  AST_RAS_MIN_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ras_n_o) |-> ($past(age) >= AGW'(RAS_CYC - 1)) && cas_n_o); // R2
  AST_CAS_AFTER_RAS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cas_n_o) |-> !ras_n_o && $past(!ras_n_o)); // R4
  AST_WE_WITH_CAS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_n_o |-> !cas_n_o && oe_n_o && dq_oe_o); // R6
  AST_RD_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |=> !rd_valid_o); // R7
  AST_GNT_CLOSED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_gnt_o |-> ras_n_o && cas_n_o); // R10
  AST_RESET_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> ras_n_o && cas_n_o && !dq_oe_o); // R12
endmodule

// File: tb/tb_fpm_dram_ctrl.sv
`timescale 1ns/1ps
module tb_fpm_dram_ctrl;
  localparam int CLKP = 8;
  localparam int RASMAX_NS = 2000;

  function automatic int cyc(int ns);
    return (ns + CLKP - 1) / CLKP;
  endfunction
  function automatic int mx(int a, int b);
    return (a > b) ? a : b;
  endfunction

  localparam int RAS_C = cyc(60);
  localparam int RP_C  = cyc(40);
  localparam int CAS_C = cyc(10);
  localparam int CP_C  = cyc(10);
  localparam int RAH_C = cyc(10);
  localparam int CAH_C = cyc(10);
  localparam int RCD_C = cyc(20);
  localparam int PC_C  = cyc(25);
  localparam int RAC_C = cyc(60);
  localparam int COL_C = mx(cyc(15), cyc(30));
  localparam int MAX_C = cyc(RASMAX_NS);

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic req_valid_i = 1'b0, req_we_i = 1'b0, ref_req_i = 1'b0;
  logic [18:0] req_addr_i = '0;
  logic [7:0]  req_wdata_i = '0;
  logic req_ready_o, rd_valid_o, ref_gnt_o;
  logic [7:0] rd_data_o, dq_o;
  logic [7:0] dq_i = 8'hEE;
  logic ras_n_o, cas_n_o, we_n_o, oe_n_o, dq_oe_o;
  logic [9:0] addr_o;

  always #(CLKP/2) clk = ~clk;

  fpm_dram_ctrl #(.CLK_NS(CLKP), .T_RASMAX_NS(RASMAX_NS)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
    .req_we_i(req_we_i), .req_addr_i(req_addr_i), .req_wdata_i(req_wdata_i),
    .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o), .ref_req_i(ref_req_i), .ref_gnt_o(ref_gnt_o),
    .ras_n_o(ras_n_o), .cas_n_o(cas_n_o), .we_n_o(we_n_o), .oe_n_o(oe_n_o), .addr_o(addr_o),
    .dq_o(dq_o), .dq_oe_o(dq_oe_o), .dq_i(dq_i)
  );

  int n_chk = 0, n_fail = 0;
  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  typedef struct packed { logic we; logic [9:0] row; logic [8:0] col; logic [7:0] d; } cmd_t;
  cmd_t cmd_q[$];
  logic [7:0] rd_q[$];
  logic [7:0] ref_mem [bit [18:0]];
  logic [7:0] dev_mem [bit [18:0]];

  // driver: pushes expectations, then hands the request over
  task automatic issue(input bit we, input logic [18:0] a, input logic [7:0] d);
    cmd_t c;
    c.we = we; c.row = a[18:9]; c.col = a[8:0]; c.d = d;
    cmd_q.push_back(c);
    if (we) ref_mem[a] = d;
    else rd_q.push_back(ref_mem.exists(a) ? ref_mem[a] : 8'h00);
    @(negedge clk);
    req_valid_i = 1'b1; req_we_i = we; req_addr_i = a; req_wdata_i = d;
    while (!req_ready_o) @(negedge clk);
    @(negedge clk);
    req_valid_i = 1'b0;
  endtask

  task automatic drain();
    int guard = 0;
    while ((cmd_q.size() != 0 || rd_q.size() != 0) && guard < 2000) begin
      @(negedge clk); guard++;
    end
    repeat (20) @(negedge clk);
  endtask

  // device model: pins sampled mid-cycle, level durations counted in cycles
  logic p_ras = 1'b1, p_cas = 1'b1;
  logic [9:0] p_addr = '0, row_lat = '0;
  logic [8:0] col_lat = '0;
  int ras_lo = 0, ras_hi = 1000, cas_lo = 0, cas_hi = 1000, pc_cnt = 1000;
  int ras_falls = 0, ras_lo_max = 0;
  bit cas_seen = 1'b0;
  always @(negedge clk) begin
    if (rst_ni) begin
      if (p_ras && !ras_n_o) begin
        chk(ras_hi >= RP_C, "R3 precharge", ras_hi, RP_C);
        row_lat = addr_o; ras_lo = 1; ras_falls++; cas_seen = 1'b0;
      end else if (!ras_n_o) ras_lo++;
      if (!p_ras && ras_n_o) begin
        chk(ras_lo >= RAS_C, "R2 ras low", ras_lo, RAS_C);
        chk(cas_n_o, "R2 ras rise with cas high", cas_n_o, 1);
        chk(ras_lo <= MAX_C, "R11 ras max", ras_lo, MAX_C);
        ras_hi = 1;
      end else if (ras_n_o) ras_hi++;
      if (!ras_n_o && ras_lo > ras_lo_max) ras_lo_max = ras_lo;
      if (!ras_n_o && !p_ras && cas_n_o && p_cas && addr_o != p_addr)
        chk(ras_lo - 1 >= RAH_C, "R4 row hold", ras_lo - 1, RAH_C);
      if (p_cas && !cas_n_o) begin
        cmd_t e;
        chk(!ras_n_o, "R4 cas under ras", ras_n_o, 0);
        if (!cas_seen) chk(ras_lo - 1 >= RCD_C, "R4 ras to cas", ras_lo - 1, RCD_C);
        else begin
          chk(cas_hi >= CP_C, "R5 cas precharge", cas_hi, CP_C);
          chk(pc_cnt >= PC_C, "R5 page cycle", pc_cnt, PC_C);
        end
        cas_seen = 1'b1; pc_cnt = 1; cas_lo = 1;
        col_lat = addr_o[8:0];
        chk(addr_o[9] == 1'b0, "R1 col msb", addr_o[9], 0);
        if (cmd_q.size() == 0) chk(1'b0, "R1 unexpected cycle", 0, 1);
        else begin
          e = cmd_q.pop_front();
          chk(row_lat == e.row, "R1 row", row_lat, e.row);
          chk(col_lat == e.col, "R1 col", col_lat, e.col);
          chk(we_n_o == !e.we, "R6/R7 we", we_n_o, !e.we);
          if (!we_n_o) begin
            chk(dq_oe_o && oe_n_o, "R6 write enables", {dq_oe_o, oe_n_o}, 3);
            chk(dq_o == e.d, "R6 write data", dq_o, e.d);
            dev_mem[{row_lat, col_lat}] = dq_o;
          end else begin
            chk(!dq_oe_o && !oe_n_o, "R7 read enables", {dq_oe_o, oe_n_o}, 0);
          end
        end
      end else begin
        pc_cnt++;
        if (!cas_n_o) begin
          cas_lo++;
          if (addr_o != p_addr) chk(cas_lo - 1 >= CAH_C, "R4 col hold", cas_lo - 1, CAH_C);
        end
      end
      if (!p_cas && cas_n_o) begin
        chk(cas_lo >= CAS_C, "R5 cas low", cas_lo, CAS_C);
        cas_hi = 1;
      end else if (cas_n_o) cas_hi++;
      if (!we_n_o && cas_n_o) chk(1'b0, "R6 we without cas", we_n_o, 1);
      if (!ras_n_o && !cas_n_o && we_n_o && !oe_n_o && ras_lo >= RAC_C && cas_lo >= COL_C)
        dq_i = dev_mem.exists({row_lat, col_lat}) ? dev_mem[{row_lat, col_lat}] : 8'h00;
      else dq_i = 8'hEE;
      p_ras = ras_n_o; p_cas = cas_n_o; p_addr = addr_o;
    end
  end

  // monitor: read results in order
  logic [7:0] exp_rd;
  always @(negedge clk) begin
    if (rst_ni && rd_valid_o) begin
      if (rd_q.size() == 0) chk(1'b0, "R7 unexpected rd_valid", rd_data_o, 0);
      else begin
        exp_rd = rd_q.pop_front();
        chk(rd_data_o == exp_rd, "R7 read data", rd_data_o, exp_rd);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    int f0;
    bit rdy_leak;
    repeat (3) @(negedge clk);
    chk(ras_n_o && cas_n_o && we_n_o && oe_n_o, "R12 strobes in reset",
        {ras_n_o, cas_n_o, we_n_o, oe_n_o}, 4'hF);
    chk(!dq_oe_o && !rd_valid_o, "R12 enables in reset", {dq_oe_o, rd_valid_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(req_ready_o, "R12 ready after reset", req_ready_o, 1);

    // page hits in one row
    f0 = ras_falls;
    for (int i = 0; i < 4; i++) issue(1'b1, {10'd5, 9'(i * 37)}, 8'(8'h10 + i));
    for (int i = 0; i < 4; i++) issue(1'b0, {10'd5, 9'(i * 37)}, 8'h00);
    drain();
    chk(ras_falls - f0 == 1, "R8 one row open for hits", ras_falls - f0, 1);

    // alternating rows
    f0 = ras_falls;
    issue(1'b1, {10'd1, 9'd3}, 8'hA1);
    issue(1'b1, {10'd2, 9'd3}, 8'hA2);
    issue(1'b0, {10'd1, 9'd3}, 8'h00);
    issue(1'b0, {10'd2, 9'd3}, 8'h00);
    drain();
    chk(ras_falls - f0 == 4, "R9 each miss reopens", ras_falls - f0, 4);

    // address extremes
    issue(1'b1, 19'h00000, 8'h5A);
    issue(1'b1, 19'h7FFFF, 8'hC3);
    issue(1'b0, 19'h00000, 8'h00);
    issue(1'b0, 19'h7FFFF, 8'h00);
    issue(1'b1, 19'h7FFFF, 8'h3C);
    issue(1'b0, 19'h7FFFF, 8'h00);
    drain();

    // refresh closes the open row
    issue(1'b0, {10'd5, 9'd0}, 8'h00);
    drain();
    chk(!ras_n_o, "R10 row open before refresh", ras_n_o, 0);
    @(negedge clk);
    ref_req_i = 1'b1;
    rdy_leak = 1'b0;
    for (int i = 0; i < 60 && !ref_gnt_o; i++) begin
      @(negedge clk);
      if (req_ready_o) rdy_leak = 1'b1;
    end
    chk(ref_gnt_o, "R10 grant given", ref_gnt_o, 1);
    chk(ras_n_o && cas_n_o, "R10 closed at grant", {ras_n_o, cas_n_o}, 3);
    chk(ras_hi >= RP_C, "R10 precharged at grant", ras_hi, RP_C);
    repeat (5) @(negedge clk);
    if (req_ready_o) rdy_leak = 1'b1;
    chk(!rdy_leak, "R10 no accept during refresh", rdy_leak, 0);
    chk(ref_gnt_o && ras_n_o, "R10 grant held", {ref_gnt_o, ras_n_o}, 3);
    ref_req_i = 1'b0;
    f0 = ras_falls;
    issue(1'b0, {10'd5, 9'd37}, 8'h00);
    drain();
    chk(ras_falls - f0 == 1, "R10 fresh row after refresh", ras_falls - f0, 1);

    // idle open row must close by itself
    repeat (MAX_C + 100) @(negedge clk);
    chk(ras_n_o, "R11 idle row closed", ras_n_o, 1);
    chk(ras_lo_max <= MAX_C, "R11 longest ras low", ras_lo_max, MAX_C);

    // back-to-back read then write to one word
    issue(1'b0, {10'd9, 9'd100}, 8'h00);
    issue(1'b1, {10'd9, 9'd100}, 8'h77);
    issue(1'b0, {10'd9, 9'd100}, 8'h00);
    drain();
    chk(cmd_q.size() == 0 && rd_q.size() == 0, "R1 all cycles seen", cmd_q.size() + rd_q.size(), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule